// File: doc/BRIEF.md
# Conversion and Power-Mode Sequencer

This block is the converter-side control machine of a sampling converter. A falling edge on the active-low conversion-start input moves the track-and-hold into hold. It then times the conversion with a counter driven by the internal clock. When the count expires it publishes the result and pulses an end-of-conversion strobe. The analog successive-approximation core is modelled by a test code that is captured when the conversion starts.

The level of the start input at the end of conversion selects the power mode. If the level is high, the block stays powered and is ready for the next start. If it is low, the block powers down. A later rising edge begins a power-up delay of fixed length, after which conversions are accepted again. Result reads are handled by an external shifter, which reports each finished read together with the number of serial clock cycles it lasted. A read that is cut short arms a software reset. That reset executes at the next end of conversion.

Top module: `conv_pwr_seq`

## Requirements
- R1: While and after synchronous reset `rst`: `hold`=0, `eoc`=0, `powered`=1, `rst_pend`=0, `err`=0 and `result`=0.
- R2: In the ready state, a falling edge on `convst_n` raises `hold` in the next cycle. `hold` then stays high for exactly CONV_CYC cycles.
- R3: `eoc` is high for exactly one cycle, and that cycle is the first one after `hold` drops. At that point `result` shows the `test_code` that was present at the clock edge that detected the start edge. Changes to `test_code` during the conversion have no effect.
- R4: If `convst_n` is high at the last conversion clock edge, `powered` stays 1 and the next falling edge starts a new conversion.
- R5: If `convst_n` is low at the last conversion clock edge, `powered` goes to 0 in the same cycle that `eoc` is high. It stays 0, with `hold` low, for as long as `convst_n` stays low.
- R6: While powered down, a rising edge on `convst_n` starts power-up. `powered` stays 0 for PWRUP_CYC cycles after the rising edge is detected and then returns to 1.
- R7: A falling edge on `convst_n` during a conversion or during power-up does not change the timing of `hold` or `powered`. It sets `err`, which stays set until `rst`.
- R8: A pulse on `rd_done` whose `rd_sclk_cnt` is between 2 and 8 inclusive sets `rst_pend` in the next cycle. Any other count leaves `rst_pend` unchanged.
- R9: At an end of conversion with `rst_pend` set, `result` becomes 0 instead of the captured code, and `rst_pend` clears in the same cycle that `eoc` is high.
- R10: `result` changes only in a cycle where `eoc` is high, so a result remains readable through power-down and power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| convst_n | input | 1 | Conversion start (falling edge) and power-mode select level |
| test_code | input | RES_W | Stand-in for the analog core's conversion code |
| rd_done | input | 1 | One-cycle pulse when a result read ends (chip select released) |
| rd_sclk_cnt | input | SCLK_CNT_W | Serial clock cycles counted in the read that just ended |
| hold | output | 1 | 1 = track-and-hold in hold (conversion running), 0 = track |
| eoc | output | 1 | One-cycle end-of-conversion strobe |
| powered | output | 1 | 1 = ready or converting, 0 = powered down or powering up |
| rst_pend | output | 1 | Software reset armed, executes at next end of conversion |
| err | output | 1 | Sticky: a start edge arrived while busy |
| result | output | RES_W | Latest conversion result |

## Verification
The bench builds the block with CONV_CYC=5 and PWRUP_CYC=20. These values are short enough that every cycle of a conversion window and every cycle of a power-up window can be checked, and that a start edge can be placed deep inside either window. Random runs cover codes, power-down choices and read lengths from 0 to 15, which includes both boundaries of the reset window. Directed cases add glitches during conversion and during power-up, a long powered-down dwell, and a reset-armed conversion.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_CONV  = 2'd1,
        ST_DOWN  = 2'd2,
        ST_WAKE  = 2'd3
    } seq_st_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_ev_t;

    function automatic int unsigned span_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

    function automatic logic in_window(input int unsigned n, input int unsigned lo,
                                       input int unsigned hi);
        return (n >= lo) && (n <= hi);
    endfunction

endpackage

// File: rtl/cps_edge.sv
module cps_edge
    import cps_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sig_n,
    output edge_ev_t ev
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b1;
        else     sig_q <= sig_n;
    end

    always_comb begin
        ev.fall = sig_q & ~sig_n;
        ev.rise = ~sig_q & sig_n;
    end
endmodule

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] lim_in,
    output logic          done,
    output logic          running
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_q;

    assign done = running && (cnt == lim_q - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            lim_q   <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            lim_q   <= lim_in;
            running <= 1'b1;
        end else if (done) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < lim_q));
endmodule

// File: rtl/cps_rst_req.sv
module cps_rst_req
    import cps_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned WIN_LO = 2,
    parameter int unsigned WIN_HI = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_done,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic             exec,
    output logic             pend
);
    logic req;

    assign req = rd_done && in_window(int'(rd_cnt), WIN_LO, WIN_HI);

    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b0;
        else if (req)  pend <= 1'b1;
        else if (exec) pend <= 1'b0;
    end

    // R8
    req_arms_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> pend);
endmodule

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq
    import cps_pkg::*;
#(
    parameter int unsigned CONV_CYC   = 33,
    parameter int unsigned PWRUP_CYC  = 5000,
    parameter int unsigned RES_W      = 12,
    parameter int unsigned SCLK_CNT_W = 5,
    parameter int unsigned RST_LO     = 2,
    parameter int unsigned RST_HI     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  convst_n,
    input  logic [RES_W-1:0]      test_code,
    input  logic                  rd_done,
    input  logic [SCLK_CNT_W-1:0] rd_sclk_cnt,
    output logic                  hold,
    output logic                  eoc,
    output logic                  powered,
    output logic                  rst_pend,
    output logic                  err,
    output logic [RES_W-1:0]      result
);
    localparam int unsigned CW = span_width(CONV_CYC, PWRUP_CYC);

    seq_st_t          st;
    edge_ev_t         ev;
    logic             conv_go;
    logic             wake_go;
    logic             tmr_done;
    logic             tmr_run;
    logic             conv_end;
    logic [CW-1:0]    tmr_lim;
    logic [RES_W-1:0] sample_q;

    cps_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .sig_n (convst_n),
        .ev    (ev)
    );

    assign conv_go  = (st == ST_READY) && ev.fall;
    assign wake_go  = (st == ST_DOWN) && ev.rise;
    assign tmr_lim  = conv_go ? CW'(CONV_CYC) : CW'(PWRUP_CYC);
    assign conv_end = (st == ST_CONV) && tmr_done;

    cps_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (conv_go | wake_go),
        .lim_in  (tmr_lim),
        .done    (tmr_done),
        .running (tmr_run)
    );

    cps_rst_req #(
        .CNT_W  (SCLK_CNT_W),
        .WIN_LO (RST_LO),
        .WIN_HI (RST_HI)
    ) u_rreq (
        .clk     (clk),
        .rst     (rst),
        .rd_done (rd_done),
        .rd_cnt  (rd_sclk_cnt),
        .exec    (conv_end),
        .pend    (rst_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_READY;
            eoc      <= 1'b0;
            err      <= 1'b0;
            sample_q <= '0;
            result   <= '0;
        end else begin
            eoc <= 1'b0;
            if (ev.fall && (st == ST_CONV || st == ST_WAKE))
                err <= 1'b1;
            unique case (st)
                ST_READY: if (conv_go) begin
                    st       <= ST_CONV;
                    sample_q <= test_code;
                end
                ST_CONV: if (tmr_done) begin
                    eoc    <= 1'b1;
                    result <= rst_pend ? '0 : sample_q;
                    st     <= convst_n ? ST_READY : ST_DOWN;
                end
                ST_DOWN: if (wake_go) st <= ST_WAKE;
                ST_WAKE: if (tmr_done) st <= ST_READY;
                default: st <= ST_READY;
            endcase
        end
    end

    assign hold    = (st == ST_CONV);
    assign powered = (st == ST_READY) || (st == ST_CONV);

    // R2
    hold_timed_chk: assert property (@(posedge clk) disable iff (rst)
        hold |-> tmr_run);
    // R3
    eoc_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> eoc);
    // R3
    eoc_single_chk: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);
    // R5
    pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(powered) |-> (eoc && !$past(convst_n)));
    // R6
    wake_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(powered) |-> !hold);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_pend) |-> eoc);
    // R10
    result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !eoc |-> $stable(result));
endmodule

// File: tb/conv_pwr_seq_tb.sv
module conv_pwr_seq_tb;
    localparam int unsigned C  = 5;
    localparam int unsigned P  = 20;
    localparam int unsigned RW = 12;
    localparam int unsigned SW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          convst_n = 1'b1;
    logic [RW-1:0] test_code = '0;
    logic          rd_done = 1'b0;
    logic [SW-1:0] rd_sclk_cnt = '0;
    logic          hold, eoc, powered, rst_pend, err;
    logic [RW-1:0] result;

    int checks = 0;
    int failures = 0;
    bit exp_pend = 1'b0;
    bit exp_err = 1'b0;
    logic [RW-1:0] exp_res = '0;

    always #2 clk = ~clk;

    conv_pwr_seq #(.CONV_CYC(C), .PWRUP_CYC(P), .RES_W(RW), .SCLK_CNT_W(SW)) u_dut (
        .clk(clk), .rst(rst), .convst_n(convst_n), .test_code(test_code),
        .rd_done(rd_done), .rd_sclk_cnt(rd_sclk_cnt), .hold(hold), .eoc(eoc),
        .powered(powered), .rst_pend(rst_pend), .err(err), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit arms(input int n);
        return (n >= 2) && (n <= 8);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(input int n);
        @(negedge clk);
        rd_done = 1'b1;
        rd_sclk_cnt = SW'(n);
        @(negedge clk);
        rd_done = 1'b0;
        if (arms(n)) exp_pend = 1'b1;
        chk(rst_pend == exp_pend, "R8 rst_pend after read", rst_pend, exp_pend);
    endtask

    task automatic do_conv(input logic [RW-1:0] code, input bit pd, input bit glitch);
        @(negedge clk);
        test_code = code;
        convst_n = 1'b0;
        for (int i = 0; i < int'(C); i++) begin
            @(negedge clk);
            chk(hold == 1'b1, "R2 hold during conversion", hold, 1);
            chk(eoc == 1'b0, "R3 no early eoc", eoc, 0);
            if (i == 0) begin
                test_code = ~code;
                if (!pd) convst_n = 1'b1;
            end
            if (glitch && i == 1) convst_n = 1'b0;
            if (glitch && i == 2) convst_n = 1'b1;
        end
        exp_res = exp_pend ? '0 : code;
        exp_err = exp_err | glitch;
        @(negedge clk);
        chk(hold == 1'b0, "R2 hold ends", hold, 0);
        chk(eoc == 1'b1, "R3 eoc strobe", eoc, 1);
        chk(result == exp_res, "R3/R9 result", result, exp_res);
        chk(rst_pend == 1'b0, "R9 pend cleared at eoc", rst_pend, 0);
        chk(powered == !pd, pd ? "R5 power-down entry" : "R4 stays powered", powered, !pd);
        exp_pend = 1'b0;
        @(negedge clk);
        chk(eoc == 1'b0, "R3 eoc one cycle", eoc, 0);
        chk(err == exp_err, "R7 err flag", err, exp_err);
    endtask

    task automatic do_wake(input bit glitch);
        @(negedge clk);
        convst_n = 1'b1;
        for (int i = 0; i < int'(P); i++) begin
            @(negedge clk);
            chk(powered == 1'b0, "R6 powering up", powered, 0);
            if (glitch && i == 3) convst_n = 1'b0;
            if (glitch && i == 4) convst_n = 1'b1;
        end
        exp_err = exp_err | glitch;
        @(negedge clk);
        chk(powered == 1'b1, "R6 powered after delay", powered, 1);
        chk(result == exp_res, "R10 result kept across power cycle", result, exp_res);
        chk(err == exp_err, "R7 err after wake", err, exp_err);
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        chk(hold == 0 && eoc == 0 && powered == 1 && rst_pend == 0 && err == 0 && result == 0,
            "R1 reset state", {hold, eoc, powered, rst_pend, err}, 5'b00100);
        rst = 1'b0;
        idle(2);
        chk(powered == 1 && result == 0, "R1 after reset", powered, 1);

        do_conv(12'hA5C, 1'b0, 1'b0);
        idle(1);
        do_conv(12'h001, 1'b0, 1'b0);       // R4 back-to-back
        do_read(1);                          // R8 below window
        do_read(9);                          // R8 above window
        do_read(2);                          // R8 lower bound
        do_conv(12'hFFF, 1'b1, 1'b0);        // R9 with power-down
        idle(10);
        chk(powered == 0 && hold == 0, "R5 stays down while low", powered, 0);
        chk(result == 0, "R10 result held in power-down", result, 0);
        do_wake(1'b0);
        do_read(8);                          // R8 upper bound
        do_conv(12'h7E1, 1'b0, 1'b1);        // R7 glitch in conversion, R9
        do_conv(12'h3C3, 1'b1, 1'b0);
        do_wake(1'b1);                       // R7 glitch in power-up
        do_conv(12'h555, 1'b0, 1'b0);

        for (int k = 0; k < 40; k++) begin
            logic [RW-1:0] code = RW'($urandom);
            bit pd = ($urandom % 4) == 0;
            if (($urandom % 3) == 0) do_read(int'($urandom % 16));
            do_conv(code, pd, 1'b0);
            if (pd) begin
                idle(1 + int'($urandom % 5));
                do_wake(1'b0);
            end
            idle(1 + int'($urandom % 3));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule